// File: doc/BRIEF.md
# Four-Class Integer ALU

This block is the combinational arithmetic and logic unit of a small 32-bit load/store processor core. It takes two operands and a 5-bit packed function word and produces a result, a flag that is high when every result bit is zero, and a copy of the result's top bit. The branch logic uses the flag and the top bit to decide branches.

The function word selects one of four result classes. The first class builds an upper-immediate constant from the low half of the second operand. The second is a signed set-on-less-than. The third is addition or subtraction. The fourth is a bitwise logic operation. A single adder serves addition and subtraction. The set-on-less-than class takes its answer from the sign of that adder's difference, corrected when the subtraction overflows. Because the block is combinational, a result is valid in the same cycle as its operands.

Top module: `mf_alu`

## Requirements
- R1: With class field (word bits 1:0) = 2 and bit 4 = 0, result equals opnd_x + opnd_y modulo 2^32.
- R2: With class field = 2 and bit 4 = 1, result equals opnd_x - opnd_y modulo 2^32.
- R3: With class field = 1 and bit 4 = 1, result is 1 when opnd_x < opnd_y as signed two's-complement values and 0 otherwise. This holds also when the difference overflows, and bits 31:1 are always zero.
- R4: With class field = 3, the logic code in word bits 3:2 selects 0 = AND, 1 = OR, 2 = XOR, 3 = NOR of the operands. Bit 4 has no effect on the result.
- R5: With class field = 0, result is {opnd_y[15:0], 16'h0000}. opnd_x and opnd_y[31:16] have no effect.
- R6: zero_flag is 1 exactly when all 32 result bits are zero.
- R7: sign_bit equals result bit 31 in every class.
- R8: Outside the logic class, word bits 3:2 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_x | input | 32 | First operand |
| opnd_y | input | 32 | Second operand, or immediate in its low half |
| func_word | input | 5 | {sub, logic code[1:0], class[1:0]} |
| result | output | 32 | Selected result |
| zero_flag | output | 1 | All result bits zero |
| sign_bit | output | 1 | Result bit 31 |

## Verification
The hardest case to reach is set-on-less-than when the subtraction overflows. In that case the raw sign of the difference gives the wrong answer, and random operands reach it rarely. The stimulus therefore places operands at the two ends of the signed range, such as the most negative value against small positives and the most positive value against the most negative, so that both directions of the overflow correction are exercised. Unused field bits are also set to nonzero values on purpose, so that a decode which leaks them into the result shows up.

// File: rtl/mf_alu_pkg.sv
package mf_alu_pkg;
  localparam int unsigned WORD_W = 5;

  typedef enum logic [1:0] {
    CLS_UPPER = 2'd0,
    CLS_LESS  = 2'd1,
    CLS_ARITH = 2'd2,
    CLS_LOGIC = 2'd3
  } fn_class_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOR = 2'd3
  } logic_code_e;

  typedef struct packed {
    logic        sub;
    logic_code_e lcode;
    fn_class_e   cls;
  } fn_word_t;

  // Signed overflow of a + b_eff = s, judged from operand and result signs.
  function automatic logic add_overflow(input logic a_s, input logic b_s,
                                        input logic s_s);
    return (a_s == b_s) && (s_s != a_s);
  endfunction

  // Signed less-than from the difference sign and its overflow.
  function automatic logic less_from_diff(input logic diff_s, input logic ovf);
    return diff_s ^ ovf;
  endfunction
endpackage

// File: rtl/mf_alu_adder.sv
module mf_alu_adder #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         carry_out,
  output logic         ovf
);
  import mf_alu_pkg::*;

  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  always_comb begin
    b_eff     = b ^ {W{sub}};
    wide      = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
    sum       = wide[W-1:0];
    carry_out = wide[W];
    ovf       = add_overflow(a[W-1], b_eff[W-1], wide[W-1]);
  end
endmodule

// File: rtl/mf_alu_logic.sv
module mf_alu_logic #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]              a,
  input  logic [W-1:0]              b,
  input  mf_alu_pkg::logic_code_e   code,
  output logic [W-1:0]              out
);
  import mf_alu_pkg::*;

  always_comb begin
    unique case (code)
      LG_AND:  out = a & b;
      LG_OR:   out = a | b;
      LG_XOR:  out = a ^ b;
      default: out = ~(a | b);
    endcase
  end
endmodule

// File: rtl/mf_alu_select.sv
module mf_alu_select #(
  parameter int unsigned W     = 32,
  parameter int unsigned IMM_W = 16
) (
  input  mf_alu_pkg::fn_class_e cls,
  input  logic [IMM_W-1:0]      imm,
  input  logic                  less,
  input  logic [W-1:0]          arith,
  input  logic [W-1:0]          lgc,
  output logic [W-1:0]          out
);
  import mf_alu_pkg::*;

  localparam int unsigned PAD_W = W - IMM_W;

  logic [W-1:0] upper_val;
  logic [W-1:0] less_val;

  assign upper_val = {imm, {PAD_W{1'b0}}};
  assign less_val  = {{(W-1){1'b0}}, less};

  always_comb begin
    unique case (cls)
      CLS_UPPER: out = upper_val;
      CLS_LESS:  out = less_val;
      CLS_ARITH: out = arith;
      default:   out = lgc;
    endcase
  end
endmodule

// File: rtl/mf_alu.sv
module mf_alu #(
  parameter int unsigned W     = 32,
  parameter int unsigned IMM_W = 16
) (
  input  logic [W-1:0]                   opnd_x,
  input  logic [W-1:0]                   opnd_y,
  input  logic [mf_alu_pkg::WORD_W-1:0]  func_word,
  output logic [W-1:0]                   result,
  output logic                           zero_flag,
  output logic                           sign_bit
);
  import mf_alu_pkg::*;

  fn_word_t     fw;
  logic [W-1:0] add_sum;
  logic         add_cout;
  logic         add_ovf;
  logic         less_bit;
  logic [W-1:0] logic_out;

  assign fw = fn_word_t'(func_word);

  mf_alu_adder #(.W(W)) u_adder (
    .a(opnd_x), .b(opnd_y), .sub(fw.sub),
    .sum(add_sum), .carry_out(add_cout), .ovf(add_ovf)
  );

  assign less_bit = less_from_diff(add_sum[W-1], add_ovf);

  mf_alu_logic #(.W(W)) u_logic (
    .a(opnd_x), .b(opnd_y), .code(fw.lcode), .out(logic_out)
  );

  mf_alu_select #(.W(W), .IMM_W(IMM_W)) u_sel (
    .cls(fw.cls), .imm(opnd_y[IMM_W-1:0]), .less(less_bit),
    .arith(add_sum), .lgc(logic_out), .out(result)
  );

  assign zero_flag = ~|result;
  assign sign_bit  = result[W-1];

  logic unused_cout;
  assign unused_cout = add_cout;
endmodule

// File: rtl/mf_alu_chk.sv
module mf_alu_chk #(
  parameter int unsigned W     = 32,
  parameter int unsigned IMM_W = 16
) (
  input logic [W-1:0] opnd_x,
  input logic [W-1:0] opnd_y,
  input logic [4:0]   func_word,
  input logic [W-1:0] result,
  input logic         zero_flag,
  input logic         sign_bit,
  input logic [W-1:0] add_sum
);
  always_comb begin
    if (func_word[1:0] == 2'd2 && !func_word[4])
      AST_ADD_INVERSE: assert (result - opnd_y == opnd_x); // R1
    if (func_word[1:0] == 2'd2 && func_word[4])
      AST_SUB_INVERSE: assert (result + opnd_y == opnd_x); // R2
    if (func_word[1:0] == 2'd1)
      AST_LESS_NARROW: assert (result[W-1:1] == '0); // R3
    if (func_word[1:0] == 2'd3 && func_word[3:2] == 2'd2)
      AST_XOR_UNDO: assert ((result ^ opnd_y) == opnd_x); // R4
    if (func_word[1:0] == 2'd0)
      AST_UPPER_LOW_CLEAR: assert (result[W-IMM_W-1:0] == '0); // R5
    if (zero_flag)
      AST_ZERO_MEANS_CLEAR: assert (result == '0); // R6
    if (func_word[1:0] == 2'd2)
      AST_SIGN_FROM_ADDER: assert (sign_bit == add_sum[W-1]); // R7
  end
endmodule

bind mf_alu mf_alu_chk #(.W(W), .IMM_W(IMM_W)) u_chk (
  .opnd_x(opnd_x), .opnd_y(opnd_y), .func_word(func_word),
  .result(result), .zero_flag(zero_flag), .sign_bit(sign_bit),
  .add_sum(add_sum)
);

// File: tb/mf_alu_tb.sv
module mf_alu_tb;
  typedef struct packed {
    logic [31:0] res;
    logic        zf;
    logic        sb;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opnd_x = '0;
  logic [31:0] opnd_y = '0;
  logic [4:0]  func_word = 5'b00010;
  logic [31:0] result;
  logic        zero_flag;
  logic        sign_bit;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  exp_t  exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  mf_alu u_dut (
    .opnd_x(opnd_x), .opnd_y(opnd_y), .func_word(func_word),
    .result(result), .zero_flag(zero_flag), .sign_bit(sign_bit)
  );

  function automatic logic [31:0] model(input logic [31:0] a,
                                        input logic [31:0] b,
                                        input logic [4:0] w);
    case (w[1:0])
      2'd0: return b << 16;
      2'd1: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      2'd2: return w[4] ? a + ~b + 32'd1 : a + b;
      default: begin
        case (w[3:2])
          2'd0: return a & b;
          2'd1: return a | b;
          2'd2: return a ^ b;
          default: return ~a & ~b;
        endcase
      end
    endcase
  endfunction

  task automatic drive(input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] w, input string tag);
    exp_t e;
    @(negedge clk);
    opnd_x = a; opnd_y = b; func_word = w;
    e.res = model(a, b, w);
    e.zf  = (e.res == 32'd0);
    e.sb  = e.res[31];
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_checks++;
      if (result !== e.res || zero_flag !== e.zf || sign_bit !== e.sb) begin
        n_fail++;
        $display("FAIL %s: got res=%h z=%b s=%b expected res=%h z=%b s=%b",
                 t, result, zero_flag, sign_bit, e.res, e.zf, e.sb);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // reset-time idle: add of zeros
    drive(32'h0, 32'h0, 5'b00010, "R6 idle zero");
    // R1 add
    drive(32'h0000_1234, 32'h0000_4321, 5'b00010, "R1 add small");
    drive(32'hFFFF_FFFF, 32'h0000_0001, 5'b00010, "R1 add wrap R6");
    drive(32'h7FFF_FFFF, 32'h0000_0001, 5'b00010, "R1 add to sign R7");
    // R8 logic bits ignored outside logic class
    drive(32'h0000_1234, 32'h0000_4321, 5'b01110, "R8 add code bits");
    drive(32'h0000_0010, 32'h0000_0003, 5'b11010, "R8 sub code bits");
    // R2 sub
    drive(32'h0000_0010, 32'h0000_0003, 5'b10010, "R2 sub");
    drive(32'h0000_0003, 32'h0000_0010, 5'b10010, "R2 sub negative R7");
    drive(32'hDEAD_BEEF, 32'hDEAD_BEEF, 5'b10010, "R2 sub equal R6");
    // R3 less-than
    drive(32'hFFFF_FFFF, 32'h0000_0001, 5'b10001, "R3 neg lt pos");
    drive(32'h0000_0005, 32'h0000_0003, 5'b10001, "R3 not lt R6");
    drive(32'h0000_0007, 32'h0000_0007, 5'b10001, "R3 equal");
    drive(32'h8000_0000, 32'h0000_0001, 5'b10001, "R3 overflow lt");
    drive(32'h7FFF_FFFF, 32'h8000_0000, 5'b10001, "R3 overflow not lt");
    drive(32'h8000_0000, 32'h7FFF_FFFF, 5'b11101, "R3 overflow lt code bits R8");
    // R4 logic
    drive(32'hF0F0_AAAA, 32'hFF00_5555, 5'b00011, "R4 and");
    drive(32'hF0F0_AAAA, 32'hFF00_5555, 5'b10111, "R4 or sub bit");
    drive(32'hF0F0_AAAA, 32'hFF00_5555, 5'b01011, "R4 xor");
    drive(32'hF0F0_AAAA, 32'hFF00_5555, 5'b11011, "R4 xor sub bit");
    drive(32'hF0F0_AAAA, 32'h0F0F_5555, 5'b01111, "R4 nor zero R6");
    drive(32'h0000_0000, 32'h0000_0000, 5'b11111, "R4 nor ones R7");
    // R5 upper immediate
    drive(32'h1357_9BDF, 32'hABCD_8765, 5'b00000, "R5 upper sign R7");
    drive(32'hFFFF_FFFF, 32'hFFFF_0000, 5'b11100, "R5 upper zero R6");
    drive(32'h0000_0001, 32'h0000_1234, 5'b01000, "R5 upper R8");
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule